// File: doc/BRIEF.md
# XOR-Key Gradual Address Remapper

This block sits between a requester and a memory whose cells tolerate a limited number of writes. It turns each logical cell address into a physical one by XOR with one of two keys: the old key and the new key. While writes go by, it moves every cell from its old-key location to its new-key location. It does this a little at a time, so that no burst of maintenance traffic ever blocks the port for long.

The logical address space holds a power-of-two number of cells. Each logical address i has a partner, i XOR old XOR new. The two cells of a pair trade places in a single migration step: two reads, then two writes. A sweep pointer walks the address space, and one step runs after every `WRITES_PER_STEP` accepted writes. When the pointer wraps, the migration is complete. The new key then becomes the old key, and a fresh key is taken from the `key_in` port. Whatever drives that port, for example a free-running pseudo-random source, decides how unpredictable the mapping is.

The sequencer is a state machine with six named states:
- `ST_IDLE` serves requests.
- `ST_STEP` decides whether the current pair still needs to be exchanged.
- `ST_FETCH_OLD` and `ST_FETCH_NEW` read the two cells.
- `ST_STORE_OLD` and `ST_STORE_NEW` write them back crossed over.

The transitions are:
- `ST_IDLE` goes to `ST_STEP` on the write that fills the write quota.
- `ST_STEP` goes to `ST_FETCH_OLD` when the pair is unswapped, or back to `ST_IDLE` when the pair was already handled.
- The fetch and store states follow one another in a fixed line.
- `ST_STORE_NEW` returns to `ST_IDLE` and advances the pointer.

Top module: `xkey_remapper`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_we` is 0. The sweep pointer and the write count are zero, the old key is zero and the new key is the value on `key_in` during reset. As a result, an idle address i shows up on `mem_addr` unchanged.
- R2: In the cycle a request is accepted, `mem_addr` is i XOR new when min(i, i XOR old XOR new) is below the sweep pointer, and i XOR old otherwise. In that same cycle, `mem_we` equals `req_write` and `mem_wdata` equals `req_wdata`.
- R3: An accepted read makes exactly one physical access, with `mem_we` at 0. In the next cycle `rsp_valid` is 1 and `rsp_rdata` carries the memory's read data. `rsp_valid` is never 1 at any other time.
- R4: Every `WRITES_PER_STEP`-th accepted write (counted from reset, with the count clearing to zero) starts a migration step, and `req_ready` is 0 in the following cycle.
- R5: When the sweep pointer p is below its partner q = p XOR old XOR new, the step reads p XOR old and then p XOR new, then writes them back crossed over: old location first, new location second. `req_ready` stays 0 for exactly 5 cycles.
- R6: When p is not below its partner, the pair is treated as already exchanged. No memory write happens, and `req_ready` is 0 for exactly 1 cycle.
- R7: The sweep pointer advances by exactly one at the end of each step, and by no other amount.
- R8: At the step that moves the pointer past the last address, the pointer returns to zero, the old key takes the value of the new key, and the new key loads `key_in` as sampled in that step's final cycle.
- R9: A read of logical address i returns the data most recently written to i, across any number of steps and key rotations, including rounds whose two keys are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Logical cell address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| key_in | input | ADDR_W | Fresh key, sampled at reset and at rotation |
| mem_addr | output | ADDR_W | Physical cell address |
| mem_we | output | 1 | Physical write enable |
| mem_wdata | output | DATA_W | Physical write data |
| mem_rdata | input | DATA_W | Physical read data, valid one cycle after the address |

## Verification
The hardest situations to reach are the ones where translation takes its new-key branch only because the partner, not the address itself, lies below the pointer. Close to these are the rounds whose two keys coincide, where every step must be skipped. A long stream of writes drives the pointer through many complete rounds, and the bench changes `key_in` only after each rotation according to a schedule that sometimes repeats the previous key. Every address is read back often, with its physical address predicted arithmetically. Every stall is timed against the swap-or-skip rule.

// File: rtl/xkr_pkg.sv
package xkr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_FETCH_OLD,
        ST_FETCH_NEW,
        ST_STORE_OLD,
        ST_STORE_NEW
    } seq_state_e;
endpackage

// File: rtl/xkr_translate.sv
module xkr_translate #(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] key_old,
    input  logic [ADDR_W-1:0] key_new,
    input  logic [ADDR_W-1:0] sweep,
    output logic [ADDR_W-1:0] phys
);
    logic [ADDR_W-1:0] partner;
    logic [ADDR_W-1:0] pair_low;

    always_comb begin
        partner  = addr ^ key_old ^ key_new;
        pair_low = (addr < partner) ? addr : partner;
        // A pair is migrated once its lower member lies below the sweep pointer.
        phys     = (pair_low < sweep) ? (addr ^ key_new) : (addr ^ key_old);
    end
endmodule

// File: rtl/xkr_pacer.sv
module xkr_pacer #(
    parameter int WRITES_PER_STEP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fire,
    output logic last_slot
);
    localparam int CW = (WRITES_PER_STEP > 1) ? $clog2(WRITES_PER_STEP) : 1;
    localparam logic [CW-1:0] LAST = CW'(WRITES_PER_STEP - 1);

    logic [CW-1:0] cnt_q;

    assign last_slot = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_fire) begin
            cnt_q <= last_slot ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/xkey_remapper.sv
module xkey_remapper
    import xkr_pkg::*;
#(
    parameter int ADDR_W          = 3,
    parameter int DATA_W          = 8,
    parameter int WRITES_PER_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [ADDR_W-1:0] key_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [ADDR_W-1:0] PTR_LAST = '1;

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] key_old_q, key_new_q, sweep_q;
    logic [DATA_W-1:0] hold_q;
    logic              rsp_q;
    logic [ADDR_W-1:0] req_phys;
    logic [ADDR_W-1:0] loc_old, loc_new, sweep_partner;
    logic              need_swap, wr_fire, rd_fire, last_slot, advance;

    xkr_translate #(.ADDR_W(ADDR_W)) u_translate (
        .addr    (req_addr),
        .key_old (key_old_q),
        .key_new (key_new_q),
        .sweep   (sweep_q),
        .phys    (req_phys)
    );

    xkr_pacer #(.WRITES_PER_STEP(WRITES_PER_STEP)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_fire),
        .last_slot (last_slot)
    );

    assign loc_old       = sweep_q ^ key_old_q;
    assign loc_new       = sweep_q ^ key_new_q;
    assign sweep_partner = sweep_q ^ key_old_q ^ key_new_q;
    assign need_swap     = (sweep_q < sweep_partner);
    assign wr_fire       = req_valid && req_ready && req_write;
    assign rd_fire       = req_valid && req_ready && !req_write;
    assign advance       = ((state_q == ST_STEP) && !need_swap) || (state_q == ST_STORE_NEW);
    assign rsp_valid     = rsp_q;
    assign rsp_rdata     = mem_rdata;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        mem_addr  = req_phys;
        mem_we    = 1'b0;
        mem_wdata = req_wdata;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                mem_we    = req_valid && req_write;
                if (req_valid && req_write && last_slot) state_d = ST_STEP;
            end
            ST_STEP: begin
                state_d = need_swap ? ST_FETCH_OLD : ST_IDLE;
            end
            ST_FETCH_OLD: begin
                mem_addr = loc_old;
                state_d  = ST_FETCH_NEW;
            end
            ST_FETCH_NEW: begin
                mem_addr = loc_new;
                state_d  = ST_STORE_OLD;
            end
            ST_STORE_OLD: begin
                mem_addr  = loc_old;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
                state_d   = ST_STORE_NEW;
            end
            ST_STORE_NEW: begin
                mem_addr  = loc_new;
                mem_we    = 1'b1;
                mem_wdata = hold_q;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Keys, sweep pointer, swap holding register, read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_old_q <= '0;
            key_new_q <= key_in;
            sweep_q   <= '0;
            hold_q    <= '0;
            rsp_q     <= 1'b0;
        end else begin
            rsp_q <= rd_fire;
            if (state_q == ST_FETCH_NEW) hold_q <= mem_rdata;
            if (advance) begin
                if (sweep_q == PTR_LAST) begin
                    sweep_q   <= '0;
                    key_old_q <= key_new_q;
                    key_new_q <= key_in;
                end else begin
                    sweep_q <= sweep_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xkey_remapper_checker.sv
module xkey_remapper_checker #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_we,
    input logic              last_slot,
    input logic [ADDR_W-1:0] sweep,
    input logic [ADDR_W-1:0] key_old,
    input logic [ADDR_W-1:0] key_new
);
    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    assert_rsp_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    assert_read_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |-> !mem_we);

    assert_stall_after_quota_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && last_slot) |=> !req_ready);

    assert_store_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we) && !req_ready) |=> mem_we);

    assert_sweep_by_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sweep) |-> (sweep == ADDR_W'($past(sweep) + 1'b1)));

    assert_key_rotate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_old) |-> ((key_old == $past(key_new)) && (sweep == '0)));
endmodule

bind xkey_remapper xkey_remapper_checker #(.ADDR_W(ADDR_W)) u_xkey_remapper_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_we    (mem_we),
    .last_slot (last_slot),
    .sweep     (sweep_q),
    .key_old   (key_old_q),
    .key_new   (key_new_q)
);

// File: tb/xkey_remapper_bench.sv
`timescale 1ns/1ps
module xkey_remapper_bench;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int T  = 2;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] key_in = 3'd3;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] phys [N];

    int checks = 0, errors = 0;
    int m_old, m_new, m_ptr, m_wc, key_idx;
    int ref_data [N];
    bit done = 0;

    always #4 clk = ~clk;

    xkey_remapper #(.ADDR_W(AW), .DATA_W(DW), .WRITES_PER_STEP(T)) u_xkey_remapper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .key_in(key_in),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) phys[mem_addr] <= mem_wdata;
        mem_rdata <= phys[mem_addr];
    end

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic int expect_phys(int a);
        int p, lo;
        p  = a ^ m_old ^ m_new;
        lo = (a < p) ? a : p;
        return (lo < m_ptr) ? (a ^ m_new) : (a ^ m_old);
    endfunction

    function automatic int key_schedule(int j, int cur);
        return (j % 4 == 3) ? cur : ((cur * 5 + 3) & 7);
    endfunction

    task automatic do_write(int a, int d);
        bit swap;
        int stall;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = DW'(d);
        #1;
        check_eq("R2", "write mem_addr", int'(mem_addr), expect_phys(a));
        check_eq("R2", "write mem_we", int'(mem_we), 1);
        @(negedge clk);
        req_valid = 0; req_write = 0;
        ref_data[a] = d;
        m_wc++;
        if (m_wc == T) begin
            m_wc = 0;
            swap = (m_ptr < (m_ptr ^ m_old ^ m_new));
            check_eq("R4", "ready after quota write", int'(req_ready), 0);
            stall = 0;
            while (!req_ready && stall < 20) begin
                stall++;
                @(negedge clk);
            end
            if (swap) check_eq("R5", "swap stall cycles", stall, 5);
            else      check_eq("R6", "skip stall cycles", stall, 1);
            m_ptr++;
            if (m_ptr == N) begin
                // R8: rotation uses the key held on key_in during the step
                m_ptr = 0;
                m_old = m_new;
                m_new = int'(key_in);
                key_idx++;
                key_in = AW'(key_schedule(key_idx, int'(key_in)));
            end
        end
    endtask

    task automatic do_read(int a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = AW'(a);
        #1;
        check_eq("R2", "read mem_addr", int'(mem_addr), expect_phys(a));
        check_eq("R3", "read mem_we", int'(mem_we), 0);
        @(negedge clk);
        req_valid = 0;
        check_eq("R3", "rsp_valid", int'(rsp_valid), 1);
        check_eq("R9", "read data", int'(rsp_rdata), ref_data[a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) phys[i] = '0;
        rst_n = 0;
        key_in = 3'd3;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_old = 0; m_new = 3; m_ptr = 0; m_wc = 0; key_idx = 0;
        key_in = AW'(key_schedule(key_idx, 3));
        req_addr = 3'd5;
        #1;
        check_eq("R1", "ready after reset", int'(req_ready), 1);
        check_eq("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        check_eq("R1", "mem_we after reset", int'(mem_we), 0);
        check_eq("R1", "identity map after reset", int'(mem_addr), 5);
        @(negedge clk);
        check_eq("R3", "no response without read", int'(rsp_valid), 0);

        for (int i = 0; i < N; i++) do_write(i, 16 + i);
        for (int i = 0; i < N; i++) do_read(i);

        for (int k = 0; k < 240; k++) begin
            int a;
            a = ((k * 3) + (k / 7)) & 7;
            if (k % 10 < 3) a = 6;
            do_write(a, (k * 37 + 11) & 255);
            if (k % 4 == 0) begin
                for (int i = 0; i < N; i++) do_read(i);
            end else begin
                do_read(a);
                do_read(a ^ 1);
            end
        end
        for (int i = 0; i < N; i++) do_read(i);
        finish_run();
    end
endmodule